// File: doc/BRIEF.md
# I2C-controlled 16-pin GPIO expander with change interrupt

The block gives a bus controller sixteen general-purpose pins, grouped as two byte-wide ports, behind a two-wire serial target interface. Each pin can be an input or an output. Output pins follow a stored output byte. Input pins can be read back with a per-bit sense inversion. An active-low interrupt line tells the controller that some input pin no longer matches the value it last read.

The serial clock and data lines are brought into a fast system clock domain through synchronisers. All protocol handling is done with sampled edges, and the data line is only ever pulled low. A transfer opens with the seven-bit target address. A write then carries a command byte that picks one of eight registers, followed by data bytes. A read returns bytes starting at the register the last command picked. In both directions, successive bytes alternate between the two ports of the selected register pair.

Top module: `gpio_expander_i2c`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `int_n` is 1, `pin_out` is 16'hFFFF, and reading back gives output bytes 8'hFF, inversion bytes 8'h00 and direction bytes 8'hFF.
- R2: The target answers only to address {4'b0100, addr_sel[2:0]}. It pulls SDA low in the acknowledge slot of a matching address. A non-matching address gets no acknowledge, and the data that follows changes no register.
- R3: Direction bit 1 means input and bit 0 means output. `pin_oe[i]` is 1 exactly when pin i is an output. Port 0 maps to pins 7:0 and port 1 to pins 15:8.
- R4: Each output pin carries its bit of the output register of its port on `pin_out`.
- R5: The low three bits of the command byte select the register: 0/1 input port 0/1, 2/3 output 0/1, 4/5 inversion 0/1, 6/7 direction 0/1. After each data byte, written or read, the port bit of the selection toggles, so bytes alternate between the two ports of the pair.
- R6: Reading an input register returns the current pin states of that port XOR its inversion byte. Other registers read back unchanged.
- R7: `int_n` goes low when some pin configured as input differs from the input register bit captured for it. Pins configured as outputs never cause the interrupt.
- R8: Reading a port's input register captures that port's pins. This clears the interrupt caused by that port only. A pin going back to its captured value also clears it.
- R9: Data bytes written to the input registers are ignored. Outputs, directions and the interrupt are left unchanged.
- R10: SDA is only ever pulled low, and it is released after every STOP. During a read the target keeps sending while the controller acknowledges. A not-acknowledge from the controller ends the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 3 | Low three bits of the target address |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enable, 1 = pin driven |
| int_n | output | 1 | Active-low interrupt |

## Verification
The delicate overlap is an input pin changing in the same system cycle in which a read of its port captures the pins. The capture and the change-detect compare then act on the same synchronised sample. The bench provokes this by sweeping the moment of a pin toggle across a window of cycles around the load of the read byte. It judges each trial by consistency: the interrupt must be high after the transfer exactly when the byte returned equals the pins now present, and the byte must be either the old or the new pin value.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int BYTE_W = 8;
   localparam int NPORT  = 2;
   localparam int NPIN   = BYTE_W * NPORT;

   typedef enum logic [1:0] {
      GRP_IN  = 2'd0,
      GRP_OUT = 2'd1,
      GRP_INV = 2'd2,
      GRP_DIR = 2'd3
   } reg_grp_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
   } bus_st_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad
      $error("gpx_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_i2c_tgt.sv
module gpx_i2c_tgt
   import gpx_pkg::*;
#(
   parameter logic [3:0] ADDR_HI     = 4'b0100,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr_sel,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [2:0]        wr_sel,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_req,
   output logic [2:0]        rd_sel,
   input  logic [BYTE_W-1:0] rd_data
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   logic scl_s, sda_s, scl_d, sda_d;
   logic scl_rise, scl_fall, start_c, stop_c;
   bus_st_e state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sr, tx;
   logic [2:0]        ptr;
   logic addr_ph, cmd_ph, is_read, mack_ok;

   gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

   assign rd_req = scl_fall && ((state == ST_ACK && is_read) ||
                                (state == ST_MACK && mack_ok));
   assign rd_sel = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1; sda_d <= 1'b1;
         state <= ST_IDLE; cnt <= '0; sr <= '0; tx <= '0; ptr <= '0;
         addr_ph <= 1'b0; cmd_ph <= 1'b0; is_read <= 1'b0; mack_ok <= 1'b0;
         sda_oe <= 1'b0; wr_en <= 1'b0; wr_sel <= '0; wr_data <= '0;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
         wr_en <= 1'b0;
         if (start_c) begin
            state <= ST_RX; cnt <= '0; addr_ph <= 1'b1; sda_oe <= 1'b0;
         end else if (stop_c) begin
            state <= ST_IDLE; sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     sr  <= {sr[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     cnt <= '0;
                     if (addr_ph) begin
                        addr_ph <= 1'b0;
                        if (sr[7:1] == {ADDR_HI, addr_sel}) begin
                           is_read <= sr[0]; cmd_ph <= ~sr[0];
                           state <= ST_ACK; sda_oe <= 1'b1;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (cmd_ph) begin
                        ptr <= sr[2:0]; cmd_ph <= 1'b0;
                        state <= ST_ACK; sda_oe <= 1'b1;
                     end else begin
                        wr_en <= 1'b1; wr_sel <= ptr; wr_data <= sr;
                        ptr[0] <= ~ptr[0];
                        state <= ST_ACK; sda_oe <= 1'b1;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (is_read) begin
                        tx <= rd_data; sda_oe <= ~rd_data[BYTE_W-1];
                        ptr[0] <= ~ptr[0]; state <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0; state <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) cnt <= cnt + 1'b1;
                  else if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_oe <= 1'b0; state <= ST_MACK;
                     end else begin
                        tx <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack_ok <= ~sda_s;
                  else if (scl_fall) begin
                     cnt <= '0;
                     if (mack_ok) begin
                        tx <= rd_data; sda_oe <= ~rd_data[BYTE_W-1];
                        ptr[0] <= ~ptr[0]; state <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R10: the line is never pulled while the interface is idle
   assert_sda_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R10: a STOP always leaves the line released
   assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !sda_oe);
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPIN-1:0]   pin_in,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic [2:0]        rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              int_n
);
   logic [NPORT-1:0][BYTE_W-1:0] pin_s, out_all, inv_all, dir_all, in_all, diff;

   gpx_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [BYTE_W-1:0] out_q, inv_q, dir_q, in_q;
      logic hit_w, hit_c;
      assign hit_w = wr_en && (wr_sel[0] == 1'(p));
      assign hit_c = rd_req && (rd_sel == {GRP_IN, 1'(p)});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '1; inv_q <= '0; dir_q <= '1; in_q <= '0;
         end else begin
            if (hit_w) begin
               unique case (reg_grp_e'(wr_sel[2:1]))
                  GRP_OUT: out_q <= wr_data;
                  GRP_INV: inv_q <= wr_data;
                  GRP_DIR: dir_q <= wr_data;
                  default: ;
               endcase
            end
            if (hit_c) in_q <= pin_s[p];
         end
      end

      assign out_all[p] = out_q;
      assign inv_all[p] = inv_q;
      assign dir_all[p] = dir_q;
      assign in_all[p]  = in_q;
      assign diff[p]    = (pin_s[p] ^ in_q) & dir_q;
      assign pin_out[p*BYTE_W +: BYTE_W] = out_q;
      assign pin_oe[p*BYTE_W +: BYTE_W]  = ~dir_q;
   end

   always_comb begin
      unique case (reg_grp_e'(rd_sel[2:1]))
         GRP_IN:  rd_data = pin_s[rd_sel[0]] ^ inv_all[rd_sel[0]];
         GRP_OUT: rd_data = out_all[rd_sel[0]];
         GRP_INV: rd_data = inv_all[rd_sel[0]];
         default: rd_data = dir_all[rd_sel[0]];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_n <= 1'b1;
      else        int_n <= ~|diff;
   end

   // R8: the captured input value only moves on a read of an input port
   assert_capture_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && rd_sel[2:1] == GRP_IN) |=> $stable(in_all));

   // R9: a write aimed at an input register leaves every writable register alone
   assert_input_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel[2:1] == GRP_IN) |=> $stable({out_all, inv_all, dir_all}));

   // R3: pad direction only changes after a direction write
   assert_dir_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel[2:1] == GRP_DIR) |=> $stable(pin_oe));

   // R7: no interrupt while no pin was configured as an input
   assert_int_needs_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !int_n |-> $past(|dir_all));
endmodule

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c
   import gpx_pkg::*;
#(
   parameter logic [3:0] ADDR_HI     = 4'b0100,
   parameter int         SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      addr_sel,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_oe,
   input  logic [NPIN-1:0] pin_in,
   output logic [NPIN-1:0] pin_out,
   output logic [NPIN-1:0] pin_oe,
   output logic            int_n
);
   logic              wr_en, rd_req;
   logic [2:0]        wr_sel, rd_sel;
   logic [BYTE_W-1:0] wr_data, rd_data;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 2..4");
   end

   gpx_i2c_tgt #(.ADDR_HI(ADDR_HI), .SYNC_STAGES(SYNC_STAGES)) u_tgt (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_i), .sda_i(sda_i),
      .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data));

   gpx_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data),
      .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n));
endmodule

// File: tb/gpio_expander_i2c_bench.sv
module gpio_expander_i2c_bench;
   localparam int Q = 8;
   localparam logic [6:0] MY_ADDR = {4'b0100, 3'b101};

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [15:0] pin_in = 16'h0000;
   logic sda_oe, int_n;
   logic [15:0] pin_out, pin_oe;
   logic sda_line;
   int nchk = 0, nfail = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] act_q[$];
   logic [7:0] last_rd;

   assign sda_line = sda_m & ~sda_oe;
   always #5 clk = ~clk;

   gpio_expander_i2c u_gpio_expander_i2c (
      .clk(clk), .rst_n(rst_n), .addr_sel(3'b101), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n));

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic expect_byte(string tag, logic [7:0] v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   // scoreboard monitor
   initial forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0)
         check(tag_q.pop_front(), 32'(act_q.pop_front()), 32'(exp_q.pop_front()));
   end

   task automatic wq(); repeat (Q) @(negedge clk); endtask
   task automatic waitc(int n); repeat (n) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_byte(logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv_byte(logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
      end
      wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic wr_regs(logic [6:0] a, logic [7:0] cmd, int n, logic [7:0] d0,
                          logic [7:0] d1, output logic aack);
      logic ack;
      bus_start();
      send_byte({a, 1'b0}, aack);
      if (aack) begin
         send_byte(cmd, ack);
         if (n > 0) send_byte(d0, ack);
         if (n > 1) send_byte(d1, ack);
      end
      bus_stop();
      waitc(10);
   endtask

   task automatic rd_regs(logic [7:0] cmd, int n, logic to_sb);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ack);
      send_byte(cmd, ack);
      bus_start();
      send_byte({MY_ADDR, 1'b1}, ack);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         last_rd = b;
         if (to_sb) act_q.push_back(b);
      end
      bus_stop();
      waitc(10);
      check("R10 line released after read", 32'(sda_oe), 32'd0);
   endtask

   initial begin
      #1_500_000;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic aack;
      waitc(5);
      rst_n = 1'b1;
      waitc(5);
      check("R1 reset pin_oe", 32'(pin_oe), 32'h0000);
      check("R1 reset pin_out", 32'(pin_out), 32'hFFFF);
      check("R1 reset int_n", 32'(int_n), 32'd1);
      expect_byte("R1 out0 default", 8'hFF); expect_byte("R5 R1 out1 default", 8'hFF);
      rd_regs(8'd2, 2, 1'b1);
      expect_byte("R1 inv0 default", 8'h00); expect_byte("R1 inv1 default", 8'h00);
      rd_regs(8'd4, 2, 1'b1);
      expect_byte("R1 dir0 default", 8'hFF); expect_byte("R1 dir1 default", 8'hFF);
      rd_regs(8'd6, 2, 1'b1);

      // R2: foreign address is not acknowledged and changes nothing
      wr_regs(7'h26, 8'd6, 1, 8'h00, 8'h00, aack);
      check("R2 foreign address nack", 32'(aack), 32'd0);
      check("R2 foreign write no effect", 32'(pin_oe), 32'h0000);

      // R3/R5: direction pair written in one transfer
      wr_regs(MY_ADDR, 8'd6, 2, 8'hF0, 8'h0F, aack);
      check("R2 own address ack", 32'(aack), 32'd1);
      check("R3 R5 direction pins", 32'(pin_oe), 32'hF00F);
      wr_regs(MY_ADDR, 8'd2, 2, 8'hA5, 8'h3C, aack);
      check("R4 output drive", 32'(pin_out), 32'h3CA5);
      wr_regs(MY_ADDR, 8'd3, 2, 8'h11, 8'h22, aack);
      check("R5 wrap from port1 to port0", 32'(pin_out), 32'h1122);
      expect_byte("R5 read out1", 8'h11); expect_byte("R5 read wraps to out0", 8'h22);
      rd_regs(8'd3, 2, 1'b1);

      // R6: inverted input reads, capture clears interrupt (R8)
      wr_regs(MY_ADDR, 8'd6, 2, 8'hFF, 8'hFF, aack);
      pin_in = 16'h1234;
      wr_regs(MY_ADDR, 8'd4, 2, 8'h0F, 8'hF0, aack);
      expect_byte("R6 input0 inverted", 8'h3B); expect_byte("R6 input1 inverted", 8'hE2);
      rd_regs(8'd0, 2, 1'b1);
      waitc(8);
      check("R8 int cleared by capture", 32'(int_n), 32'd1);

      // R7/R8: change, return, per-port clearing
      pin_in = 16'h123C; waitc(8);
      check("R7 input change raises int", 32'(int_n), 32'd0);
      pin_in = 16'h1234; waitc(8);
      check("R8 pin returning clears int", 32'(int_n), 32'd1);
      pin_in = 16'h1034; waitc(8);
      check("R7 port1 change raises int", 32'(int_n), 32'd0);
      expect_byte("R6 input0 unchanged", 8'h3B);
      rd_regs(8'd0, 1, 1'b1);
      check("R8 port0 read keeps port1 int", 32'(int_n), 32'd0);
      expect_byte("R6 input1 new", 8'hE0);
      rd_regs(8'd1, 1, 1'b1);
      check("R8 port1 read clears int", 32'(int_n), 32'd1);
      wr_regs(MY_ADDR, 8'd4, 2, 8'h00, 8'h00, aack);

      // R7: output pins do not interrupt
      wr_regs(MY_ADDR, 8'd6, 1, 8'h00, 8'h00, aack);
      pin_in = 16'h1035; waitc(8);
      check("R7 output pin change ignored", 32'(int_n), 32'd1);

      // R9: writes to input registers are ignored
      wr_regs(MY_ADDR, 8'd0, 2, 8'h55, 8'hAA, aack);
      check("R9 outputs untouched", 32'(pin_out), 32'h1122);
      check("R9 direction untouched", 32'(pin_oe), 32'h00FF);
      check("R9 int untouched", 32'(int_n), 32'd1);
      expect_byte("R9 out0 readback", 8'h22); expect_byte("R9 out1 readback", 8'h11);
      rd_regs(8'd2, 2, 1'b1);

      // R8/R6: pin toggle swept across the capture cycle
      wr_regs(MY_ADDR, 8'd6, 2, 8'hFF, 8'hFF, aack);
      rd_regs(8'd0, 1, 1'b0);
      for (int d = 890; d <= 950; d += 4) begin
         logic [7:0] oldv;
         oldv = pin_in[7:0];
         fork
            begin waitc(d); pin_in[0] = ~pin_in[0]; end
            rd_regs(8'd0, 1, 1'b0);
         join
         waitc(4);
         check("R6 swept read is old or new",
               32'((last_rd == oldv) || (last_rd == pin_in[7:0])), 32'd1);
         check("R8 swept int matches capture",
               32'(int_n), 32'(last_rd == pin_in[7:0]));
         rd_regs(8'd0, 1, 1'b0);
      end

      waitc(20);
      check("R10 idle line released", 32'(sda_line), 32'd1);
      check("R5 scoreboard drained", 32'(exp_q.size() + act_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule